// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block takes a 64-bit request word issued by one CPU to raise a software-generated interrupt and turns it into a series of per-CPU "mark pending" strobes. The word holds an interrupt number, a routing-mode flag, the upper three affinity bytes of the wanted destination, and a 16-bit mask indexed by the lowest affinity byte. A configuration input gives each CPU's four-byte affinity value.

When idle, the dispatcher accepts one request through a valid/ready handshake. It then visits CPUs in ascending index order, one per clock. Each visited CPU that qualifies gets a one-cycle strobe that carries its index and the interrupt number. In routing-all mode, every CPU except the requester qualifies. In targeted mode, a CPU qualifies when its upper affinity bytes match and its level-0 bit is still set in a working copy of the mask. That bit is removed once the CPU is served, so the scan can stop as soon as nothing is left to deliver. The pending-state storage that consumes the strobes lies outside this block.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, busy, done and set_valid are low and req_ready is high.
- R2: req_ready is high exactly when the block is not scanning. A request is taken on a clock edge where req_valid and req_ready are both high.
- R3: Request word fields: target mask in bits 15:0, affinity level 1 in 23:16, interrupt number in 27:24, affinity level 2 in 39:32, routing-all flag in bit 40, and affinity level 3 in 55:48. All other bits are ignored. Each CPU's configuration word holds affinity level 0 in 7:0, level 1 in 15:8, level 2 in 23:16 and level 3 in 31:24.
- R4: With the routing-all flag set, every CPU except req_src is served. The mask and affinity fields have no effect.
- R5: With the flag clear, a CPU is served only if its level 1 to 3 bytes equal the requested ones and the mask bit indexed by its level-0 byte is set. A level-0 byte of 16 or more never matches. In this mode, req_src has no effect.
- R6: Serving a CPU in targeted mode clears its level-0 bit from the working mask. A later CPU with the same level-0 byte is therefore not served.
- R7: In targeted mode, the scan ends in the cycle in which the working mask becomes zero. busy is then high for (index of that CPU + 1) cycles. Otherwise the scan covers all NUM_CPUS CPUs.
- R8: One CPU is visited per cycle, in ascending index order. Each served CPU gets exactly one set_valid cycle, with set_cpu equal to its index and set_id equal to the request's interrupt number.
- R9: A targeted request with an all-zero mask never raises busy or set_valid. done rises in the cycle after acceptance.
- R10: done is a one-cycle pulse in the cycle after the last scan cycle, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request word offered |
| req_ready | output | 1 | Dispatcher idle, request can be taken |
| req_word | input | 64 | Encoded interrupt request |
| req_src | input | IDX_W | Index of the requesting CPU |
| cpu_aff_cfg | input | NUM_CPUS*32 | Affinity word of each CPU, CPU 0 in the low bits |
| set_valid | output | 1 | Mark-pending strobe |
| set_cpu | output | IDX_W | CPU receiving the interrupt |
| set_id | output | 4 | Interrupt number to mark pending |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Request finished (one cycle) |

## Verification
The assertions assume three things about the inputs: req_src is below NUM_CPUS, cpu_aff_cfg stays constant while busy is high, and no new request arrives in the same cycle as done. Under these assumptions, the captured requester and interrupt number describe the scan in progress. The stimulus changes the configuration only between requests and always waits one idle cycle after done before offering the next word. It also uses only requester indices inside the CPU range.

// File: rtl/sgi_dispatch_pkg.sv
package sgi_dispatch_pkg;
  localparam int REQ_W    = 64;
  localparam int LIST_W   = 16;
  localparam int ID_W     = 4;
  localparam int AFF_W    = 8;
  localparam int CFG_W    = 4 * AFF_W;
  localparam int UPPER_W  = 3 * AFF_W;
  localparam int SEL_W    = $clog2(LIST_W);

  // request word field positions, fixed by the issuing CPU
  localparam int LIST_LSB = 0;
  localparam int AFF1_LSB = 16;
  localparam int ID_LSB   = 24;
  localparam int AFF2_LSB = 32;
  localparam int MODE_BIT = 40;
  localparam int AFF3_LSB = 48;

  typedef struct packed {
    logic [AFF_W-1:0]  aff3;
    logic [AFF_W-1:0]  aff2;
    logic [AFF_W-1:0]  aff1;
    logic              bcast;
    logic [ID_W-1:0]   id;
    logic [LIST_W-1:0] tlist;
  } sgi_req_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_st_e;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_dispatch_pkg::*;
(
  input  logic [REQ_W-1:0] word,
  output sgi_req_t         req,
  output logic             empty
);
  logic unused_bits;

  always_comb begin
    req.tlist = word[LIST_LSB +: LIST_W];
    req.aff1  = word[AFF1_LSB +: AFF_W];
    req.id    = word[ID_LSB +: ID_W];
    req.aff2  = word[AFF2_LSB +: AFF_W];
    req.bcast = word[MODE_BIT];
    req.aff3  = word[AFF3_LSB +: AFF_W];
  end

  // a targeted request naming nobody finishes without a scan
  assign empty = !req.bcast && (req.tlist == '0);

  assign unused_bits = ^{word[63:56], word[47:41], word[31:28]};
endmodule

// File: rtl/sgi_aff_match.sv
module sgi_aff_match
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
  input  logic [NUM_CPUS*CFG_W-1:0] cfg,
  input  logic [UPPER_W-1:0]        want_upper,
  input  logic [LIST_W-1:0]         work_list,
  input  logic                      bcast,
  input  logic [IDX_W-1:0]          src,
  input  logic [IDX_W-1:0]          idx,
  output logic                      cur_hit,
  output logic [LIST_W-1:0]         cur_clr
);
  logic [NUM_CPUS-1:0] hit_vec;
  logic [LIST_W-1:0]   clr_vec [NUM_CPUS];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [CFG_W-1:0]   aff;
    logic [AFF_W-1:0]   lvl0;
    logic               in_range;
    logic               upper_eq;
    logic               list_bit;
    logic [LIST_W-1:0]  onehot;

    assign aff      = cfg[c*CFG_W +: CFG_W];
    assign lvl0     = aff[AFF_W-1:0];
    assign in_range = (lvl0 < AFF_W'(LIST_W));
    assign upper_eq = (aff[CFG_W-1:AFF_W] == want_upper);
    assign list_bit = work_list[lvl0[SEL_W-1:0]];
    assign onehot   = in_range ? (LIST_W'(1) << lvl0[SEL_W-1:0]) : '0;

    always_comb begin
      if (bcast) begin
        hit_vec[c] = (src != IDX_W'(c));
        clr_vec[c] = '0;
      end else begin
        hit_vec[c] = upper_eq && in_range && list_bit;
        clr_vec[c] = onehot;
      end
    end
  end

  assign cur_hit = hit_vec[idx];
  assign cur_clr = cur_hit ? clr_vec[idx] : '0;
endmodule

// File: rtl/sgi_scan_ctrl.sv
module sgi_scan_ctrl
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  sgi_req_t          dec_req,
  input  logic              dec_empty,
  input  logic [IDX_W-1:0]  req_src,
  input  logic              cur_hit,
  input  logic [LIST_W-1:0] cur_clr,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  idx,
  output sgi_req_t          cur_req,
  output logic [LIST_W-1:0] work_list,
  output logic [IDX_W-1:0]  cur_src,
  output logic              set_valid,
  output logic [IDX_W-1:0]  set_cpu,
  output logic [ID_W-1:0]   set_id
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPUS - 1);

  scan_st_e          st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LIST_W-1:0] list_q, list_d;
  sgi_req_t          req_q;
  logic [IDX_W-1:0]  src_q;
  logic              done_q, done_d;
  logic              accept, req_en, idx_en, list_en, stop;

  assign accept = req_valid && (st_q == ST_IDLE);
  assign req_en = accept;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    list_d  = list_q;
    done_d  = 1'b0;
    idx_en  = 1'b0;
    list_en = 1'b0;
    stop    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          idx_d   = '0;
          idx_en  = 1'b1;
          list_d  = dec_req.tlist;
          list_en = 1'b1;
          if (dec_empty) done_d = 1'b1;
          else           st_d   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        list_d  = list_q & ~cur_clr;
        list_en = 1'b1;
        stop    = (idx_q == LAST_IDX) || (!req_q.bcast && (list_d == '0));
        if (stop) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d  = idx_q + IDX_W'(1);
          idx_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       list_q <= '0;
    else if (list_en) list_q <= list_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      src_q <= '0;
    end else if (req_en) begin
      req_q <= dec_req;
      src_q <= req_src;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q == ST_SCAN);
  assign done      = done_q;
  assign idx       = idx_q;
  assign cur_req   = req_q;
  assign work_list = list_q;
  assign cur_src   = src_q;
  assign set_valid = busy && cur_hit;
  assign set_cpu   = idx_q;
  assign set_id    = req_q.id;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [REQ_W-1:0]          req_word,
  input  logic [IDX_W-1:0]          req_src,
  input  logic [NUM_CPUS*CFG_W-1:0] cpu_aff_cfg,
  output logic                      set_valid,
  output logic [IDX_W-1:0]          set_cpu,
  output logic [ID_W-1:0]           set_id,
  output logic                      busy,
  output logic                      done
);
  sgi_req_t          dec_req, cur_req;
  logic              dec_empty;
  logic              cur_hit;
  logic [LIST_W-1:0] cur_clr, work_list;
  logic [IDX_W-1:0]  idx, cur_src;

  sgi_req_decode u_decode (
    .word  (req_word),
    .req   (dec_req),
    .empty (dec_empty)
  );

  sgi_aff_match #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W)) u_match (
    .cfg        (cpu_aff_cfg),
    .want_upper ({cur_req.aff3, cur_req.aff2, cur_req.aff1}),
    .work_list  (work_list),
    .bcast      (cur_req.bcast),
    .src        (cur_src),
    .idx        (idx),
    .cur_hit    (cur_hit),
    .cur_clr    (cur_clr)
  );

  sgi_scan_ctrl #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .dec_req   (dec_req),
    .dec_empty (dec_empty),
    .req_src   (req_src),
    .cur_hit   (cur_hit),
    .cur_clr   (cur_clr),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .idx       (idx),
    .cur_req   (cur_req),
    .work_list (work_list),
    .cur_src   (cur_src),
    .set_valid (set_valid),
    .set_cpu   (set_cpu),
    .set_id    (set_id)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
  import sgi_dispatch_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [REQ_W-1:0]          req_word,
  input logic [IDX_W-1:0]          req_src,
  input logic [NUM_CPUS*CFG_W-1:0] cpu_aff_cfg,
  input logic                      set_valid,
  input logic [IDX_W-1:0]          set_cpu,
  input logic [ID_W-1:0]           set_id,
  input logic                      busy,
  input logic                      done
);
  logic             take;
  logic             cap_bcast;
  logic [IDX_W-1:0] cap_src;
  logic [ID_W-1:0]  cap_id;
  logic             unused_cfg;

  assign take       = req_valid && req_ready;
  assign unused_cfg = ^cpu_aff_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_bcast <= 1'b0;
      cap_src   <= '0;
      cap_id    <= '0;
    end else if (take) begin
      cap_bcast <= req_word[MODE_BIT];
      cap_src   <= req_src;
      cap_id    <= req_word[ID_LSB +: ID_W];
    end
  end

  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r8_strobe_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> busy);

  a_r8_id_of_request: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |-> (set_id == cap_id));

  a_r4_skip_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && cap_bcast) |-> (set_cpu != cap_src));

  a_r9_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_word[MODE_BIT] && (req_word[LIST_LSB +: LIST_W] == '0))
      |=> (done && !busy));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !take) |=> !done);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sgi_dispatch_bench.sv
module sgi_dispatch_bench;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int NVEC  = 10;

  logic          clk, rst_n, req_valid, req_ready;
  logic [63:0]   req_word;
  logic [IW-1:0] req_src;
  logic [N*32-1:0] cfg;
  logic          set_valid, busy, done;
  logic [IW-1:0] set_cpu;
  logic [3:0]    set_id;

  int checks = 0;
  int errors = 0;

  sgi_dispatch #(.NUM_CPUS(N)) u_sgi_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_src(req_src), .cpu_aff_cfg(cfg),
    .set_valid(set_valid), .set_cpu(set_cpu), .set_id(set_id),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // word layout (R3): mask 15:0, aff1 23:16, id 27:24, aff2 39:32, flag 40, aff3 55:48
  localparam logic [63:0] V_WORD [NVEC] = '{
    64'h00000000_0300000F,  // R5 R7: cpus 0..3, stop at 3
    64'h00000000_05010002,  // R5: aff1=1, bit1 -> cpu5
    64'h00000001_07000020,  // R5: aff2=1, bit5 -> cpu6
    64'h00000000_01000002,  // R6 R7: cpu1 only, stop at 1
    64'h00000000_02000012,  // R6: duplicate cpu7 skipped, full scan
    64'h00000100_09000000,  // R4: all but requester 2
    64'h00000103_0A0000F0,  // R4: mask and affinity ignored, requester 0
    64'h00010000_0400FFFF,  // R5: aff3 mismatch, nobody
    64'h00000000_06000000,  // R9: empty targeted request
    64'hFF00FE00_F5010002   // R3: ignored bits set, same as row 1
  };
  localparam logic [IW-1:0] V_SRC  [NVEC] = '{3'd3, 3'd0, 3'd0, 3'd1, 3'd5, 3'd2, 3'd0, 3'd0, 3'd0, 3'd4};
  localparam logic [N-1:0]  V_MASK [NVEC] = '{8'h0F, 8'h20, 8'h40, 8'h02, 8'h02, 8'hFB, 8'hFE, 8'h00, 8'h00, 8'h20};
  localparam int            V_BUSY [NVEC] = '{4, 6, 7, 2, 8, 8, 8, 8, 0, 6};
  localparam string         V_TAG  [NVEC] = '{"R5", "R5", "R5", "R6", "R6", "R4", "R4", "R5", "R9", "R3"};

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] w, input logic [IW-1:0] s,
                     input logic [N-1:0] exp_mask, input int exp_busy, input string tag);
    logic [N-1:0] got_mask = '0;
    int nbusy = 0, nstrobe = 0, ndone = 0, last = -1;
    bit id_ok = 1, order_ok = 1, ready_ok = 1, overlap_ok = 1;
    @(negedge clk);
    req_word = w; req_src = s; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      if (busy) begin
        nbusy++;
        if (req_ready) ready_ok = 0;
      end
      if (set_valid) begin
        nstrobe++;
        got_mask[set_cpu] = 1'b1;
        if (set_id != w[27:24]) id_ok = 0;
        if (int'(set_cpu) <= last) order_ok = 0;
        last = int'(set_cpu);
      end
      if (done) begin
        ndone++;
        if (busy) overlap_ok = 0;
        break;
      end
    end
    @(negedge clk);
    if (done) ndone++;
    chk(got_mask == exp_mask, tag, "served mask", got_mask, exp_mask);
    chk(nbusy == exp_busy, "R7", "busy cycles", nbusy, exp_busy);
    chk(nstrobe == $countones(exp_mask), "R8", "strobe count", nstrobe, $countones(exp_mask));
    chk(id_ok, "R8", "strobe id", set_id, w[27:24]);
    chk(order_ok, "R8", "ascending order", order_ok, 1);
    chk(ready_ok, "R2", "ready while busy", ready_ok, 1);
    chk(ndone == 1, "R10", "done pulses", ndone, 1);
    chk(overlap_ok, "R10", "done with busy", overlap_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // per-CPU affinity {aff3,aff2,aff1,aff0}
    cfg = {32'h00000001, 32'h00010005, 32'h00000101, 32'h00000100,
           32'h00000003, 32'h00000002, 32'h00000001, 32'h00000000};
    req_valid = 1'b0; req_word = '0; req_src = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !set_valid, "R1", "outputs after reset",
        {busy, done, set_valid}, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R2", "idle ready", req_ready, 1);

    for (int v = 0; v < NVEC; v++)
      run(V_WORD[v], V_SRC[v], V_MASK[v], V_BUSY[v], V_TAG[v]);

    // R5: level-0 byte of 16 or more never matches
    @(negedge clk);
    cfg[7*32 +: 32] = 32'h00000011;
    run(64'h00000000_0B00FFFF, 3'd0, 8'h0F, 8, "R5");

    // R4: requester at the top index
    run(64'h00000100_0C000000, 3'd7, 8'h7F, 8, "R4");

    // R1: reset in mid-scan returns to idle
    @(negedge clk);
    req_word = 64'h00000100_0D000000; req_src = 3'd0; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !set_valid && req_ready, "R1", "reset mid-scan",
        {busy, set_valid, req_ready}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset release", {busy, done}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule